// File: doc/BRIEF.md
# Consecutive-Cycle Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches the up and down pulses of a phase-frequency detector, sampled by a fast system clock. It measures the phase error of every comparison cycle as the number of system-clock ticks during which either pulse is active. A cycle ends when both pulses have returned low after at least one of them was high. Its measured width is then compared against two thresholds.

The lock flag is active high. It is raised only after a programmed number of consecutive cycles with a small error: three cycles with the precision select low, five with it high. Once raised, it drops only when a cycle shows an error above a second, larger threshold. The gap between the two thresholds gives hysteresis: a cycle between them breaks the run of good cycles but leaves an existing lock in place. A synchronous clear models power-down of the surrounding circuit and erases all lock history.

Top module: `pfd_lock_detect`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `locked` is 0, the good-cycle run is empty and no partial cycle is pending.
- R2: With `prec` = 0, `locked` rises at the clock edge that ends the third consecutive cycle whose width is below `GOOD_TICKS`.
- R3: With `prec` = 1, five consecutive cycles below `GOOD_TICKS` are needed. The run count saturates at `RUN_SLOW`.
- R4: A cycle whose width is at least `GOOD_TICKS` and at most `BAD_TICKS` empties the good-cycle run and leaves `locked` unchanged.
- R5: A cycle whose width exceeds `BAD_TICKS` empties the run and drives `locked` to 0.
- R6: While `clr` is high at a clock edge, `locked` goes to 0 at that edge and the run and any partial cycle are discarded. Later cycles must rebuild the full run.
- R7: The width of a cycle is the number of ticks during which `up` or `dn` (or both) is high. Overlapping and back-to-back up/down activity counts as one cycle. The width counter saturates at 2^W-1, which is treated as a large error.
- R8: A cycle is evaluated at the first edge at which both `up` and `dn` are low after at least one tick of activity. Idle ticks with no activity change neither the run nor `locked`.
- R9: A change of `prec` applies from the next cycle evaluation onward. The run already collected is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all lock state (power-down) |
| prec | input | 1 | Run length select: 0 needs 3 good cycles, 1 needs 5 |
| up | input | 1 | Sampled up pulse of the phase-frequency detector |
| dn | input | 1 | Sampled down pulse of the phase-frequency detector |
| locked | output | 1 | Lock flag, active high |

## Verification
Widths are driven from up alone, from dn alone, and from an overlapping up-then-dn pair. This separates a detector that measures the union of activity from one that watches only one pulse or splits an overlap into two cycles. Widths exactly at `GOOD_TICKS` and at `BAD_TICKS` distinguish the strict comparisons on each side of the hysteresis band. A pulse longer than the counter range shows whether saturation still reads as an unlock. Random sequences mix good, middling and bad widths with precision flips and clears. They separate run-reset behaviour from lock-clear behaviour, and show whether a precision change keeps the collected run.

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect #(
  parameter int W          = 8,
  parameter int GOOD_TICKS = 4,
  parameter int BAD_TICKS  = 7,
  parameter int RUN_FAST   = 3,
  parameter int RUN_SLOW   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic prec,
  input  logic up,
  input  logic dn,
  output logic locked
);
  localparam int RW = $clog2(RUN_SLOW + 1);
  localparam logic [W-1:0]  WMAX   = '1;
  localparam logic [W-1:0]  GOOD_W = W'(GOOD_TICKS);
  localparam logic [W-1:0]  BAD_W  = W'(BAD_TICKS);
  localparam logic [RW-1:0] FAST_R = RW'(RUN_FAST);
  localparam logic [RW-1:0] SLOW_R = RW'(RUN_SLOW);

  logic          act, was_act, done, good, bad;
  logic [W-1:0]  wid;
  logic [RW-1:0] run, run_nx, need;

  assign act    = up | dn;
  assign done   = was_act & ~act;
  assign good   = wid < GOOD_W;
  assign bad    = wid > BAD_W;
  assign need   = prec ? SLOW_R : FAST_R;
  assign run_nx = (run == SLOW_R) ? run : run + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_act <= 1'b0;
      wid     <= '0;
      run     <= '0;
      locked  <= 1'b0;
    end else if (clr) begin
      was_act <= 1'b0;
      wid     <= '0;
      run     <= '0;
      locked  <= 1'b0;
    end else begin
      was_act <= act;
      if (act) wid <= (wid == WMAX) ? wid : wid + 1'b1;
      else     wid <= '0;
      if (done) begin
        if (good) begin
          run <= run_nx;
          if (run_nx >= need) locked <= 1'b1;
        end else begin
          run <= '0;
          if (bad) locked <= 1'b0;
        end
      end
    end
  end

  // Lock is only gained at the end of a short cycle, never during a clear.
  assert_rise_on_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !$past(clr) && $past(was_act) && !$past(up | dn) && $past(wid) < GOOD_W);

  assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run <= SLOW_R);

  assert_mid_keeps_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr && locked && !good && !bad) |=> locked && run == '0);

  assert_fall_on_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(clr) || $past(wid) > BAD_W);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !locked && run == '0 && wid == '0);
endmodule

// File: tb/tb_pfd_lock_detect.sv
module tb_pfd_lock_detect;
  localparam int GOOD = 4;
  localparam int BAD  = 7;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, prec = 1'b0, up = 1'b0, dn = 1'b0;
  logic locked;
  int checks = 0, fails = 0;
  int m_run = 0;
  bit m_lock = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pfd_lock_detect #(.W(8), .GOOD_TICKS(GOOD), .BAD_TICKS(BAD), .RUN_FAST(3), .RUN_SLOW(5))
    dut (.clk(clk), .rst_n(rst_n), .clr(clr), .prec(prec), .up(up), .dn(dn), .locked(locked));

  function automatic int need_of(bit p);
    return p ? 5 : 3;
  endfunction

  task automatic check(string req, bit exp);
    checks++;
    if (locked !== exp) begin
      fails++;
      $display("FAIL %s: locked=%0b expected=%0b", req, locked, exp);
    end
  endtask

  task automatic model_eval(int k);
    if (k < GOOD) begin
      m_run = (m_run < 5) ? m_run + 1 : 5;
      if (m_run >= need_of(prec)) m_lock = 1'b1;
    end else begin
      m_run = 0;
      if (k > BAD) m_lock = 1'b0;
    end
  endtask

  // mode 0: up only, 1: dn only, 2: up then overlapping dn (one cycle)
  task automatic pulse(int k, int mode, int gap, string req);
    int split = (k + 1) / 2;
    for (int i = 0; i < k; i++) begin
      up = (mode == 0) || (mode == 2 && i < split);
      dn = (mode == 1) || (mode == 2 && i >= split - 1);
      @(negedge clk);
    end
    up = 1'b0; dn = 1'b0;
    repeat (gap) @(negedge clk);
    model_eval(k);
    check(req, m_lock);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_run = 0;
    m_lock = 1'b0;
    check("R6", 1'b0);
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);

    // R2: three good cycles with prec=0
    pulse(1, 0, 2, "R2");
    pulse(3, 1, 1, "R2");
    pulse(2, 2, 1, "R2");
    // R8: idle time changes nothing
    repeat (20) @(negedge clk);
    check("R8", m_lock);
    // R4: width exactly BAD keeps lock, width exactly GOOD breaks run
    pulse(BAD, 0, 1, "R4");
    pulse(GOOD, 1, 1, "R4");
    // R5: BAD+1 unlocks
    pulse(BAD + 1, 2, 1, "R5");

    // R3: five needed with prec=1
    prec = 1'b1;
    for (int i = 0; i < 5; i++) pulse(1 + (i % 3), i % 3, 1, "R3");
    pulse(BAD + 3, 0, 2, "R5");

    // R9: run kept across a precision change
    pulse(1, 0, 1, "R9");
    pulse(2, 1, 1, "R9");
    pulse(3, 2, 1, "R9");
    pulse(1, 0, 1, "R9");
    prec = 1'b0;
    pulse(1, 1, 1, "R9");

    // R6: clear drops lock and erases the run
    do_clear();
    pulse(1, 0, 1, "R6");
    pulse(1, 0, 1, "R6");
    do_clear();
    pulse(2, 1, 1, "R6");

    // R7: overlap counts as one cycle; saturation reads as bad
    pulse(3, 2, 1, "R7");
    pulse(3, 2, 1, "R7");
    pulse(300, 0, 1, "R7");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 100;
      if (r < 4) do_clear();
      else begin
        if (r < 10) prec = ~prec;
        pulse(1 + ($urandom % 11), $urandom % 3, 1 + ($urandom % 4), "R5");
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule